// File: doc/BRIEF.md
# Spectral Built-In Self-Test Pattern Generator

This block produces test stimulus on chip for a circuit under test. Each output lane carries one chosen Walsh function, drawn from a free-running counter of `ORDER` bits. A weighted pseudo-random noise bit can flip that value. The noise comes from a maximal-length LFSR: ANDing `m` of its bits gives a flip probability of 1/2^m, and `m` is set per lane.

A programmable divider sets how often the generator steps, relative to the system clock. Each step raises a one-cycle clock enable for a sequential circuit under test. A hold input freezes every generator register.

A tester can reseed the LFSR, the counter and the per-lane Walsh selectors in two ways:
- a parallel load, in a single cycle;
- a serial scan chain, MSB first. The pattern outputs stay constant during the scan.

Top module: `spectral_tpg`

## Requirements
- R1: After reset, `pat_out` is 0 and `bist_clk_en` is 0. The reseed chain holds LFSR = 16'h0001, counter = 0 and all selectors = 0, and this value can be read out through `scan_out`.
- R2: With `m` = 0 for a lane, bit i of `pat_out` at each step is the parity of (counter AND selector_i). The counter value used is the one before the step. The counter then increments by 1, modulo 2^ORDER.
- R3: Over 2^ORDER consecutive steps with `m` = 0 and a non-zero selector, a lane outputs exactly 2^(ORDER-1) ones.
- R4: The noise bit is the AND of LFSR bits (i*3 + j) for j < m, where i is the lane index, and it is 0 when m = 0. Each lane's `m` sits in bits [2i+1:2i] of `noise_m`. The noise bit is XORed onto the Walsh bit. The LFSR value used is the one before the step. The LFSR then shifts left, taking in bit15^bit13^bit12^bit10 at bit 0.
- R5: With `hold` low and no reseed, a step occurs every `div_ratio`+1 system clocks. `bist_clk_en` is high for exactly the one cycle after each step, and `pat_out` changes on that same edge.
- R6: While `hold` is high, the LFSR, counter, selectors, divider and `pat_out` keep their values. Parallel load and scan requests are ignored during hold, and no `bist_clk_en` pulse occurs.
- R7: A parallel load writes `pl_data` = {lfsr[30:15], counter[14:12], sel3[11:9], sel2[8:6], sel1[5:3], sel0[2:0]} in one cycle. An LFSR field of zero is replaced by 16'h0001.
- R8: When `scan_en` is high, the chain (same bit layout as R7) shifts left by one bit per cycle. `scan_in` enters at bit 0 and `scan_out` shows bit 30. `pat_out` holds and no pulse occurs. A parallel load has priority over a scan.
- R9: The LFSR is never zero after a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold | input | 1 | Freeze all generator state |
| div_ratio | input | 4 | Step period minus one, in system clocks |
| noise_m | input | 8 | Per-lane noise weight m, 2 bits per lane |
| pl_en | input | 1 | Parallel reseed strobe |
| pl_data | input | 31 | Parallel reseed value |
| scan_en | input | 1 | Serial reseed shift enable |
| scan_in | input | 1 | Serial reseed data in |
| scan_out | output | 1 | Serial reseed data out (chain MSB) |
| pat_out | output | 4 | Test pattern, one bit per lane |
| bist_clk_en | output | 1 | One-cycle enable after each step, for the circuit under test |

## Verification
The checker watches the following on every cycle:
- freezing under hold;
- the counter advancing by one per step;
- a non-zero LFSR after every step and after every load;
- the one-bit chain shift during scan, with quiet outputs;
- the minimum spacing between steps;
- each enable pulse following a step.

Only the bench scenarios can show the actual values:
- the Walsh bit values and their balance over a period;
- the exact noise masks for each weight;
- the step period for chosen ratios;
- the chain contents shifted out after reset and after a load;
- load-over-scan priority.

// File: rtl/spt_pkg.sv
package spt_pkg;

  typedef enum logic [1:0] {
    CTL_RUN   = 2'd0,
    CTL_HOLD  = 2'd1,
    CTL_LOAD  = 2'd2,
    CTL_SHIFT = 2'd3
  } spt_ctl_e;

  // Priority: hold freezes all, then parallel load, then scan shift.
  function automatic spt_ctl_e spt_decode(input logic hold, input logic pl, input logic sc);
    if (hold)    return CTL_HOLD;
    else if (pl) return CTL_LOAD;
    else if (sc) return CTL_SHIFT;
    else         return CTL_RUN;
  endfunction

  // Walsh value: parity of the bitwise AND of counter and index.
  function automatic logic walsh_parity(input logic [31:0] cnt, input logic [31:0] idx);
    return ^(cnt & idx);
  endfunction

  // Fibonacci LFSR advance: shift left, feedback is XOR of the tapped bits.
  function automatic logic [63:0] lfsr_advance(input logic [63:0] st, input logic [63:0] taps);
    return {st[62:0], ^(st & taps)};
  endfunction

endpackage

// File: rtl/spt_clkdiv.sv
module spt_clkdiv
  import spt_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  spt_ctl_e         ctl,
  input  logic [DIV_W-1:0] div_ratio,
  output logic             tick
);

  logic [DIV_W-1:0] dcnt_q;
  logic             due;

  assign due  = (dcnt_q >= div_ratio);
  assign tick = (ctl == CTL_RUN) && due;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q <= '0;
    end else begin
      unique case (ctl)
        CTL_HOLD:            dcnt_q <= dcnt_q;
        CTL_LOAD, CTL_SHIFT: dcnt_q <= '0;
        default:             dcnt_q <= due ? '0 : dcnt_q + 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/spt_state.sv
module spt_state
  import spt_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int ORDER  = 3,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS     = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED_FIX = 16'h0001
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  spt_ctl_e                      ctl,
  input  logic                          tick,
  input  logic [LFSR_W+ORDER+N_IN*ORDER-1:0] pl_data,
  input  logic                          scan_in,
  output logic [LFSR_W+ORDER+N_IN*ORDER-1:0] chain,
  output logic [LFSR_W-1:0]             lfsr,
  output logic [ORDER-1:0]              cnt,
  output logic [N_IN*ORDER-1:0]         sel
);

  localparam int SEL_W   = N_IN * ORDER;
  localparam int CHAIN_W = LFSR_W + ORDER + SEL_W;

  logic [CHAIN_W-1:0] chain_q, chain_d;
  logic [LFSR_W-1:0]  lfsr_step;

  assign lfsr  = chain_q[CHAIN_W-1 -: LFSR_W];
  assign cnt   = chain_q[SEL_W +: ORDER];
  assign sel   = chain_q[SEL_W-1:0];
  assign chain = chain_q;

  always_comb begin
    if (lfsr == '0) lfsr_step = SEED_FIX;
    else            lfsr_step = LFSR_W'(lfsr_advance(64'(lfsr), 64'(TAPS)));
  end

  always_comb begin
    chain_d = chain_q;
    unique case (ctl)
      CTL_LOAD: begin
        chain_d = pl_data;
        if (pl_data[CHAIN_W-1 -: LFSR_W] == '0) chain_d[CHAIN_W-1 -: LFSR_W] = SEED_FIX;
      end
      CTL_SHIFT: chain_d = {chain_q[CHAIN_W-2:0], scan_in};
      CTL_RUN:   if (tick) chain_d = {lfsr_step, cnt + 1'b1, sel};
      default:   chain_d = chain_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {SEED_FIX, {(ORDER + SEL_W){1'b0}}};
    else        chain_q <= chain_d;
  end

endmodule

// File: rtl/spt_mixer.sv
module spt_mixer
  import spt_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int ORDER  = 3,
  parameter int LFSR_W = 16,
  parameter int M_W    = 2
) (
  input  logic [ORDER-1:0]      cnt,
  input  logic [N_IN*ORDER-1:0] sel,
  input  logic [LFSR_W-1:0]     lfsr,
  input  logic [N_IN*M_W-1:0]   noise_m,
  output logic [N_IN-1:0]       walsh_bits,
  output logic [N_IN-1:0]       noise_bits,
  output logic [N_IN-1:0]       mix_bits
);

  localparam int M_MAX = (1 << M_W) - 1;

  for (genvar i = 0; i < N_IN; i++) begin : g_lane
    logic [ORDER-1:0] sel_i;
    logic [M_W-1:0]   m_i;
    logic             nz;

    assign sel_i = sel[i*ORDER +: ORDER];
    assign m_i   = noise_m[i*M_W +: M_W];
    assign walsh_bits[i] = walsh_parity(32'(cnt), 32'(sel_i));

    always_comb begin
      nz = (m_i != '0);
      for (int j = 0; j < M_MAX; j++) begin
        if (j < int'(m_i)) nz = nz & lfsr[(i*M_MAX + j) % LFSR_W];
      end
    end

    assign noise_bits[i] = nz;
    assign mix_bits[i]   = walsh_bits[i] ^ noise_bits[i];
  end

endmodule

// File: rtl/spectral_tpg.sv
module spectral_tpg
  import spt_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int ORDER  = 3,
  parameter int LFSR_W = 16,
  parameter int M_W    = 2,
  parameter int DIV_W  = 4,
  parameter logic [LFSR_W-1:0] TAPS     = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED_FIX = 16'h0001,
  localparam int CHAIN_W = LFSR_W + ORDER + N_IN*ORDER
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hold,
  input  logic [DIV_W-1:0]     div_ratio,
  input  logic [N_IN*M_W-1:0]  noise_m,
  input  logic                 pl_en,
  input  logic [CHAIN_W-1:0]   pl_data,
  input  logic                 scan_en,
  input  logic                 scan_in,
  output logic                 scan_out,
  output logic [N_IN-1:0]      pat_out,
  output logic                 bist_clk_en
);

  spt_ctl_e              ctl;
  logic                  tick;
  logic [CHAIN_W-1:0]    chain;
  logic [LFSR_W-1:0]     lfsr;
  logic [ORDER-1:0]      cnt;
  logic [N_IN*ORDER-1:0] sel;
  logic [N_IN-1:0]       walsh_bits, noise_bits, mix_bits;
  logic [N_IN-1:0]       pat_q;
  logic                  en_q;

  assign ctl = spt_decode(hold, pl_en, scan_en);

  spt_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .div_ratio(div_ratio), .tick(tick)
  );

  spt_state #(
    .N_IN(N_IN), .ORDER(ORDER), .LFSR_W(LFSR_W), .TAPS(TAPS), .SEED_FIX(SEED_FIX)
  ) u_state (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .tick(tick), .pl_data(pl_data),
    .scan_in(scan_in), .chain(chain), .lfsr(lfsr), .cnt(cnt), .sel(sel)
  );

  spt_mixer #(.N_IN(N_IN), .ORDER(ORDER), .LFSR_W(LFSR_W), .M_W(M_W)) u_mix (
    .cnt(cnt), .sel(sel), .lfsr(lfsr), .noise_m(noise_m),
    .walsh_bits(walsh_bits), .noise_bits(noise_bits), .mix_bits(mix_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= tick;
      if (tick) pat_q <= mix_bits;
    end
  end

  assign pat_out     = pat_q;
  assign bist_clk_en = en_q;
  assign scan_out    = chain[CHAIN_W-1];

endmodule

// File: rtl/spt_chk.sv
module spt_chk #(
  parameter int N_IN   = 4,
  parameter int ORDER  = 3,
  parameter int LFSR_W = 16,
  parameter int DIV_W  = 4,
  localparam int CHAIN_W = LFSR_W + ORDER + N_IN*ORDER
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  hold,
  input logic                  pl_en,
  input logic                  scan_en,
  input logic [DIV_W-1:0]      div_ratio,
  input logic                  scan_out,
  input logic [N_IN-1:0]       pat_out,
  input logic                  bist_clk_en,
  input logic                  tick,
  input logic [CHAIN_W-1:0]    chain,
  input logic [LFSR_W-1:0]     lfsr,
  input logic [ORDER-1:0]      cnt,
  input logic [N_IN*ORDER-1:0] sel
);

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(lfsr) && $stable(cnt) && $stable(sel) && $stable(pat_out) && !bist_clk_en); // R6

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == ORDER'($past(cnt) + 1'b1)); // R2

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> lfsr != '0); // R9

  AST_LOAD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_en && !hold) |=> lfsr != '0); // R7

  AST_SCAN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !pl_en && !hold) |=> scan_out == $past(chain[CHAIN_W-2])); // R8

  AST_SCAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !hold) |=> !bist_clk_en && $stable(pat_out)); // R8

  AST_PULSE_FOLLOWS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    bist_clk_en |-> $past(tick)); // R5

  AST_STEP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_ratio != '0) |=> (!tick || div_ratio == '0)); // R5

endmodule

bind spectral_tpg spt_chk #(
  .N_IN(N_IN), .ORDER(ORDER), .LFSR_W(LFSR_W), .DIV_W(DIV_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .pl_en(pl_en), .scan_en(scan_en),
  .div_ratio(div_ratio), .scan_out(scan_out), .pat_out(pat_out),
  .bist_clk_en(bist_clk_en), .tick(tick), .chain(chain), .lfsr(lfsr),
  .cnt(cnt), .sel(sel)
);

// File: tb/tb_spectral_tpg.sv
`timescale 1ns/1ps
module tb_spectral_tpg;

  localparam int NL = 4;
  localparam int CW = 31;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hold = 1'b1;
  logic [3:0]    div_ratio = '0;
  logic [7:0]    noise_m = '0;
  logic          pl_en = 1'b0;
  logic [CW-1:0] pl_data = '0;
  logic          scan_en = 1'b0;
  logic          scan_in = 1'b0;
  logic          scan_out;
  logic [NL-1:0] pat_out;
  logic          bist_clk_en;

  spectral_tpg dut (
    .clk(clk), .rst_n(rst_n), .hold(hold), .div_ratio(div_ratio), .noise_m(noise_m),
    .pl_en(pl_en), .pl_data(pl_data), .scan_en(scan_en), .scan_in(scan_in),
    .scan_out(scan_out), .pat_out(pat_out), .bist_clk_en(bist_clk_en)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [15:0] m_lfsr;
  logic [2:0]  m_cnt;
  logic [11:0] m_sel;

  logic [NL-1:0] exp_q[$];
  string         tag_q[$];
  int            ones[NL];
  int            cyc = 0;
  int            last_cyc = 0;
  bit            last_valid = 0;
  int            exp_gap = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] model_chain();
    return {m_lfsr, m_cnt, m_sel};
  endfunction

  function automatic logic [NL-1:0] model_pat();
    logic [NL-1:0] r;
    for (int i = 0; i < NL; i++) begin
      logic w, n;
      int   m;
      w = 1'b0;
      for (int b = 0; b < 3; b++) if (m_cnt[b] && m_sel[i*3 + b]) w = ~w;
      m = int'(noise_m[2*i +: 2]);
      n = (m > 0);
      for (int j = 0; j < m; j++) n = n && m_lfsr[i*3 + j];
      r[i] = w ^ n;
    end
    return r;
  endfunction

  task automatic model_step();
    logic fb;
    if (m_lfsr == 16'h0) m_lfsr = 16'h0001;
    else begin
      fb = m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10];
      m_lfsr = {m_lfsr[14:0], fb};
    end
    m_cnt = m_cnt + 3'd1;
  endtask

  // Monitor: pops expected patterns on each enable pulse.
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (bist_clk_en) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5/R6 unexpected bist_clk_en pulse", 64'(bist_clk_en), 64'd0);
        end else begin
          logic [NL-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(pat_out == e, t, 64'(pat_out), 64'(e));
          for (int i = 0; i < NL; i++) ones[i] += int'(pat_out[i]);
          if (last_valid && exp_gap > 0)
            chk((cyc - last_cyc) == exp_gap, "R5 step spacing", 64'(cyc - last_cyc), 64'(exp_gap));
          last_cyc   = cyc;
          last_valid = 1;
        end
      end
    end
  end

  task automatic run(input int n, input string tag);
    int got;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(model_pat());
      tag_q.push_back(tag);
      model_step();
    end
    for (int i = 0; i < NL; i++) ones[i] = 0;
    exp_gap    = int'(div_ratio) + 1;
    last_valid = 0;
    got = 0;
    @(negedge clk);
    hold = 1'b0;
    while (got < n) begin
      @(posedge clk);
      #1;
      if (bist_clk_en) got++;
    end
    hold = 1'b1;
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, {tag, " all steps seen"}, 64'(exp_q.size()), 64'd0);
  endtask

  task automatic load(input logic [CW-1:0] d);
    @(negedge clk);
    hold = 1'b0;
    pl_en = 1'b1;
    pl_data = d;
    @(negedge clk);
    pl_en = 1'b0;
    hold = 1'b1;
    {m_lfsr, m_cnt, m_sel} = d;
    if (m_lfsr == 16'h0) m_lfsr = 16'h0001;
  endtask

  task automatic scan_swap(input logic [CW-1:0] nw, input string tag);
    logic [CW-1:0] old;
    logic [NL-1:0] p0;
    old = model_chain();
    @(negedge clk);
    p0 = pat_out;
    hold = 1'b0;
    scan_en = 1'b1;
    for (int j = 0; j < CW; j++) begin
      chk(scan_out == old[CW-1-j], tag, 64'(scan_out), 64'(old[CW-1-j]));
      scan_in = nw[CW-1-j];
      @(negedge clk);
    end
    scan_en = 1'b0;
    hold = 1'b1;
    chk(pat_out == p0, "R8 pattern held during scan", 64'(pat_out), 64'(p0));
    {m_lfsr, m_cnt, m_sel} = nw;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    m_lfsr = 16'h0001; m_cnt = '0; m_sel = '0;
    repeat (3) @(negedge clk);
    chk(pat_out == '0, "R1 reset pat_out", 64'(pat_out), 64'd0);
    chk(bist_clk_en == 1'b0, "R1 reset bist_clk_en", 64'(bist_clk_en), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 / R8: shift out reset chain while shifting in a new seed
    scan_swap({16'hACE1, 3'd0, 3'd7, 3'd5, 3'd3, 3'd1}, "R1/R8 scan_out chain bit");

    // R2 / R3: pure Walsh lanes over one full period
    noise_m = 8'h00;
    div_ratio = 4'd0;
    run(8, "R2 walsh pattern");
    for (int i = 0; i < NL; i++)
      chk(ones[i] == 4, "R3 lane balance", 64'(ones[i]), 64'd4);
    run(8, "R2 walsh second period");

    // R4 / R7: weighted noise after a parallel load
    load({16'h5A3C, 3'd5, 3'd6, 3'd0, 3'd4, 3'd2});
    noise_m = {2'd0, 2'd1, 2'd2, 2'd3};
    run(16, "R4 noise m=3,2,1,0");
    noise_m = {2'd3, 2'd3, 2'd1, 2'd1};
    run(12, "R4 noise m=1,1,3,3");

    // R5: divider ratios
    noise_m = 8'h00;
    div_ratio = 4'd2;
    run(6, "R5 ratio 2");
    div_ratio = 4'd5;
    run(4, "R5 ratio 5");
    div_ratio = 4'd0;

    // R6: hold ignores load and scan
    @(negedge clk);
    pl_en = 1'b1; pl_data = 31'h7FFF_FFFF; scan_en = 1'b1; scan_in = 1'b1;
    begin
      logic [NL-1:0] p0;
      p0 = pat_out;
      repeat (4) begin
        @(negedge clk);
        chk(pat_out == p0, "R6 pattern frozen in hold", 64'(pat_out), 64'(p0));
      end
    end
    pl_en = 1'b0; scan_en = 1'b0; scan_in = 1'b0;
    run(5, "R6 state unchanged after hold");

    // R7 / R9: zero seed is replaced
    load({16'h0000, 3'd0, 3'd1, 3'd1, 3'd1, 3'd1});
    noise_m = 8'h55;
    run(6, "R7/R9 zero seed replaced");

    // R8: load wins over scan in the same cycle
    @(negedge clk);
    hold = 1'b0; pl_en = 1'b1; scan_en = 1'b1; scan_in = 1'b1;
    pl_data = {16'h1D0F, 3'd3, 3'd2, 3'd7, 3'd6, 3'd1};
    @(negedge clk);
    pl_en = 1'b0; scan_en = 1'b0; hold = 1'b1; scan_in = 1'b0;
    {m_lfsr, m_cnt, m_sel} = pl_data;
    noise_m = 8'h00;
    run(4, "R8 load priority over scan");

    // R8: read back the chain after running
    scan_swap({16'h0F0F, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5}, "R8 chain readback");
    run(4, "R2 after second scan");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule